// File: doc/BRIEF.md
# Horizon-Based Credit Time Generator

This block sits beside the output-link scheduler of one stage in a multistage burst switch fabric. For every data channel of the link, the scheduler keeps a scheduling horizon: the latest time at which that channel is already booked. The block reads all of these horizons as one flat vector. From them it works out the earliest future time at which a chosen number of channels will all be free. It publishes that time as a credit. Upstream stages may launch new bursts toward this output from that time onward, and not before.

The required number of free channels is held in a small programmable register. After reset it holds the number of upstream neighbours, and software may set it higher or lower. The credit is the k-th smallest horizon, where k is the register value. A register value of zero, or one above the channel count, makes the block publish the largest horizon.

The selection runs as a sequential odd-even transposition sort, one pass per cycle. A one-cycle `done_o` pulse marks each new credit. Any change of the horizon vector, and any write to the threshold register, starts a computation. Changes that arrive while a computation is running are merged into a single restart, which begins as soon as the current result has been published.

Top module: `hzfc_credit_gen`

## Requirements
- R1: With a threshold k from 1 to NCH, the published credit equals the k-th smallest of the NCH horizons. Horizons are unsigned values of HW bits, and channel c occupies bits [c*HW +: HW] of `horizons_i`.
- R2: After reset the threshold register holds NUM_UP (default 4). While `thr_wr_i` is high at a rising edge, the register takes `thr_wdata_i`.
- R3: A threshold of 0, or any value above NCH, makes the credit equal to the largest horizon.
- R4: `done_o` is high for exactly one cycle per result. It rises after the (NCH+2)-th rising edge, counting from the edge that first samples a changed horizon vector while the block is idle. `credit_time_o` changes only in a cycle where `done_o` is high. `busy_o` falls only together with `done_o`.
- R5: A horizon change, or a threshold write, sampled while the block is idle starts a computation, and `busy_o` is high in the following cycle. The threshold used is the value in force after that edge.
- R6: Horizon changes or threshold writes during a computation leave the running result untouched: it is still taken from the snapshot loaded at its start. They cause exactly one restart, however many of them there were, and that restart uses the latest horizons and threshold.
- R7: During and right after reset, `credit_time_o` is 0 and `done_o` and `busy_o` are low.
- R8: Driving a horizon vector equal to the last one sampled starts no computation, and `credit_time_o` keeps its value.
- R9: Equal horizons are counted individually, so when several channels tie at a value, the k-th smallest is that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| horizons_i | input | NCH*HW | Per-channel scheduling horizons, channel c at bits [c*HW +: HW] |
| thr_wr_i | input | 1 | Threshold register write strobe |
| thr_wdata_i | input | TW | Threshold write data |
| credit_time_o | output | HW | Advertised earliest send time |
| done_o | output | 1 | One-cycle pulse marking a new credit |
| busy_o | output | 1 | A computation is in progress |

## Verification
The bench targets the threshold extremes. With k = 1 the credit must be the minimum; with k = NCH, k = 0 and k = 20 it must be the maximum. A design with an off-by-one index would return a neighbouring order statistic, and one without saturation would index past the array. Vectors with heavy ties catch a selection that treats equal horizons as one entry. A burst of two updates inside one computation must produce one stale result followed by exactly one fresh result. A design that drops the pending flag would leave the credit stale, and one that counts every update would pulse `done_o` too often. Re-driving identical horizons must stay silent, which catches change detection that fires on any write rather than on a changed value.

// File: rtl/hzfc_pkg.sv
package hzfc_pkg;

  // Sequencer states for the sort-and-publish cycle.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SORT  = 2'd1,
    ST_PUBL  = 2'd2
  } hzfc_state_e;

  // Default number of upstream neighbours used as reset threshold.
  localparam int unsigned HZFC_DEF_NUM_UP = 4;

endpackage

// File: rtl/hzfc_cmp_swap.sv
module hzfc_cmp_swap #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);

  logic a_gt_b;

  always_comb begin
    a_gt_b = (a_i > b_i);
    lo_o   = a_gt_b ? b_i : a_i;
    hi_o   = a_gt_b ? a_i : b_i;
  end

endmodule

// File: rtl/hzfc_oe_pass.sv
// One pass of odd-even transposition: even phase pairs (0,1),(2,3)...,
// odd phase pairs (1,2),(3,4)... with the end elements passed through.
module hzfc_oe_pass #(
  parameter int unsigned NCH = 16,
  parameter int unsigned HW  = 32
) (
  input  logic [NCH*HW-1:0] vec_i,
  input  logic              odd_i,
  output logic [NCH*HW-1:0] vec_o
);

  localparam int unsigned NPAIR_EV = NCH / 2;
  localparam int unsigned NPAIR_OD = NCH / 2 - 1;

  logic [NCH*HW-1:0] ev_vec;
  logic [NCH*HW-1:0] od_vec;

  genvar g;
  generate
    for (g = 0; g < NPAIR_EV; g++) begin : g_even
      hzfc_cmp_swap #(.W(HW)) u_cs (
        .a_i  (vec_i[(2*g)*HW +: HW]),
        .b_i  (vec_i[(2*g+1)*HW +: HW]),
        .lo_o (ev_vec[(2*g)*HW +: HW]),
        .hi_o (ev_vec[(2*g+1)*HW +: HW])
      );
    end

    for (g = 0; g < NPAIR_OD; g++) begin : g_odd
      hzfc_cmp_swap #(.W(HW)) u_cs (
        .a_i  (vec_i[(2*g+1)*HW +: HW]),
        .b_i  (vec_i[(2*g+2)*HW +: HW]),
        .lo_o (od_vec[(2*g+1)*HW +: HW]),
        .hi_o (od_vec[(2*g+2)*HW +: HW])
      );
    end
  endgenerate

  assign od_vec[0 +: HW]             = vec_i[0 +: HW];
  assign od_vec[(NCH-1)*HW +: HW]    = vec_i[(NCH-1)*HW +: HW];

  assign vec_o = odd_i ? od_vec : ev_vec;

endmodule

// File: rtl/hzfc_seq_ctrl.sv
module hzfc_seq_ctrl
  import hzfc_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic change_i,
  output logic load_o,
  output logic pass_o,
  output logic odd_o,
  output logic publish_o,
  output logic busy_o
);

  localparam int unsigned CW = $clog2(NCH);
  localparam logic [CW-1:0] LAST_PASS = CW'(NCH - 1);

  hzfc_state_e     state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            pend_q, pend_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    pend_d    = pend_q;
    load_o    = 1'b0;
    pass_o    = 1'b0;
    publish_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (change_i) begin
          load_o  = 1'b1;
          cnt_d   = '0;
          state_d = ST_SORT;
        end
      end
      ST_SORT: begin
        pass_o = 1'b1;
        if (change_i) pend_d = 1'b1;
        if (cnt_q == LAST_PASS) begin
          state_d = ST_PUBL;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PUBL: begin
        publish_o = 1'b1;
        if (pend_q || change_i) begin
          load_o  = 1'b1;
          cnt_d   = '0;
          pend_d  = 1'b0;
          state_d = ST_SORT;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
    end
  end

  assign odd_o  = cnt_q[0];
  assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/hzfc_credit_gen.sv
module hzfc_credit_gen
  import hzfc_pkg::*;
#(
  parameter int unsigned NCH    = 16,
  parameter int unsigned HW     = 32,
  parameter int unsigned TW     = $clog2(NCH + 1),
  parameter int unsigned NUM_UP = HZFC_DEF_NUM_UP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH*HW-1:0] horizons_i,
  input  logic              thr_wr_i,
  input  logic [TW-1:0]     thr_wdata_i,
  output logic [HW-1:0]     credit_time_o,
  output logic              done_o,
  output logic              busy_o
);

  localparam int unsigned IW = $clog2(NCH);
  localparam logic [IW-1:0] MAX_IDX = IW'(NCH - 1);

  logic [NCH*HW-1:0] seen_q;
  logic [NCH*HW-1:0] work_q, work_d, pass_vec;
  logic [TW-1:0]     thr_q, thr_d, thr_use_q, thr_use_d;
  logic [HW-1:0]     credit_q, credit_d;
  logic              done_q;
  logic              change, load, pass_en, odd_ph, publish;
  logic [IW-1:0]     sel_idx;

  // A change is a differing horizon vector or any threshold write.
  assign change = (horizons_i != seen_q) || thr_wr_i;

  hzfc_seq_ctrl #(.NCH(NCH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .change_i  (change),
    .load_o    (load),
    .pass_o    (pass_en),
    .odd_o     (odd_ph),
    .publish_o (publish),
    .busy_o    (busy_o)
  );

  hzfc_oe_pass #(.NCH(NCH), .HW(HW)) u_pass (
    .vec_i (work_q),
    .odd_i (odd_ph),
    .vec_o (pass_vec)
  );

  // Next-state logic.
  always_comb begin
    thr_d     = thr_wr_i ? thr_wdata_i : thr_q;
    thr_use_d = load ? thr_d : thr_use_q;
    if (load) begin
      work_d = horizons_i;
    end else if (pass_en) begin
      work_d = pass_vec;
    end else begin
      work_d = work_q;
    end
    if ((thr_use_q == '0) || (thr_use_q > TW'(NCH))) begin
      sel_idx = MAX_IDX;
    end else begin
      sel_idx = IW'(thr_use_q - 1'b1);
    end
    credit_d = publish ? work_q[sel_idx*HW +: HW] : credit_q;
  end

  // Registers.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q    <= '0;
      work_q    <= '0;
      thr_q     <= TW'(NUM_UP);
      thr_use_q <= TW'(NUM_UP);
      credit_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      if (change)            seen_q    <= horizons_i;
      if (load || pass_en)   work_q    <= work_d;
      if (thr_wr_i)          thr_q     <= thr_d;
      if (load)              thr_use_q <= thr_use_d;
      if (publish)           credit_q  <= credit_d;
      done_q <= publish;
    end
  end

  assign credit_time_o = credit_q;
  assign done_o        = done_q;

endmodule

// File: rtl/hzfc_credit_gen_chk.sv
module hzfc_credit_gen_chk #(
  parameter int unsigned NCH = 16,
  parameter int unsigned HW  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NCH*HW-1:0] horizons_i,
  input logic [HW-1:0]     credit_time_o,
  input logic              done_o,
  input logic              busy_o
);

  // R4: a result pulse lasts exactly one cycle.
  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4: the credit moves only when a result is announced.
  a_r4_credit_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (credit_time_o != $past(credit_time_o)) |-> done_o);

  // R4: a result always follows a busy period.
  a_r4_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));

  // R4: leaving the busy state coincides with a published result.
  a_r4_busy_fall_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R5: a fresh horizon vector seen while idle starts a computation.
  a_r5_idle_change_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (horizons_i != $past(horizons_i))) |=> busy_o);

endmodule

bind hzfc_credit_gen hzfc_credit_gen_chk #(.NCH(NCH), .HW(HW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .horizons_i    (horizons_i),
  .credit_time_o (credit_time_o),
  .done_o        (done_o),
  .busy_o        (busy_o)
);

// File: tb/hzfc_credit_gen_tb.sv
module hzfc_credit_gen_tb;

  localparam int unsigned NCH = 16;
  localparam int unsigned HW  = 32;
  localparam int unsigned TW  = 5;
  localparam int          LAT = NCH + 2;
  localparam int          NV  = 6;

  // Vector table: seed of the horizon pattern, threshold, tie-heavy flag.
  localparam int unsigned V_SEED [NV] = '{3, 17, 29, 41, 53, 67};
  localparam int unsigned V_THR  [NV] = '{4, 1, 9, 16, 2, 12};
  localparam bit          V_DUP  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  logic              clk;
  logic              rst_n;
  logic [NCH*HW-1:0] hz;
  logic              thr_wr;
  logic [TW-1:0]     thr_wdata;
  logic [HW-1:0]     credit;
  logic              done;
  logic              busy;

  int n_chk;
  int n_bad;
  int cur_thr;

  hzfc_credit_gen #(.NCH(NCH), .HW(HW), .TW(TW), .NUM_UP(4)) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .horizons_i    (hz),
    .thr_wr_i      (thr_wr),
    .thr_wdata_i   (thr_wdata),
    .credit_time_o (credit),
    .done_o        (done),
    .busy_o        (busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [HW-1:0] act, input logic [HW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [NCH*HW-1:0] build(input int unsigned seed, input bit dup);
    logic [NCH*HW-1:0] v;
    for (int c = 0; c < NCH; c++) begin
      logic [31:0] h;
      h = seed * 32'h9E37_79B1 + c * 32'h7F4A_7C15;
      h = h ^ (h >> 13);
      if (dup) h = (h & 32'h3) + 32'd100;
      v[c*HW +: HW] = h;
    end
    return v;
  endfunction

  // Order statistic by counting, saturating k to NCH when out of range.
  function automatic logic [HW-1:0] ref_kth(input logic [NCH*HW-1:0] v, input int k);
    int ke;
    ke = (k == 0 || k > NCH) ? NCH : k;
    for (int i = 0; i < NCH; i++) begin
      int lt;
      int le;
      lt = 0;
      le = 0;
      for (int j = 0; j < NCH; j++) begin
        if (v[j*HW +: HW] <  v[i*HW +: HW]) lt++;
        if (v[j*HW +: HW] <= v[i*HW +: HW]) le++;
      end
      if (lt < ke && le >= ke) return v[i*HW +: HW];
    end
    return '0;
  endfunction

  // Call right after driving at a negedge; returns rising edges until done.
  task automatic wait_done(input string tag, output int cyc);
    cyc = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (done) return;
    end
    check({tag, " done timeout"}, 32'd0, 32'd1);
  endtask

  task automatic write_thr(input int t);
    @(negedge clk);
    thr_wr    = 1'b1;
    thr_wdata = TW'(t);
    @(negedge clk);
    thr_wr    = 1'b0;
    cur_thr   = t;
  endtask

  task automatic count_dones(input int cycles, output int nd);
    nd = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (done) nd++;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int cyc;
    int nd;
    logic [NCH*HW-1:0] cur_hz, a_hz, b_hz, c_hz;
    logic [HW-1:0]     held;

    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    hz = '0;
    thr_wr = 1'b0;
    thr_wdata = '0;
    cur_thr = 4;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 credit in reset", credit, 32'd0);
    check("R7 done in reset", {31'd0, done}, 32'd0);
    check("R7 busy in reset", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 credit after reset", credit, 32'd0);
    check("R7 busy after reset", {31'd0, busy}, 32'd0);

    // R2: default threshold of 4 upstream neighbours
    cur_hz = build(11, 1'b0);
    hz = cur_hz;
    wait_done("R2", cyc);
    check("R4 latency", cyc, LAT);
    check("R2 default threshold credit", credit, ref_kth(cur_hz, 4));
    @(negedge clk);
    check("R4 done one cycle", {31'd0, done}, 32'd0);
    check("R4 busy low after result", {31'd0, busy}, 32'd0);

    // Vector table: threshold write then new horizons
    for (int v = 0; v < NV; v++) begin
      if (V_THR[v] != cur_thr) begin
        write_thr(V_THR[v]);
        wait_done("R5", cyc);
        check("R5 threshold write recomputes", credit, ref_kth(cur_hz, V_THR[v]));
      end
      @(negedge clk);
      cur_hz = build(V_SEED[v], V_DUP[v]);
      hz = cur_hz;
      wait_done("R1", cyc);
      check("R4 latency per vector", cyc, LAT);
      if (V_DUP[v]) check("R9 tied horizons", credit, ref_kth(cur_hz, cur_thr));
      else          check("R1 kth smallest", credit, ref_kth(cur_hz, cur_thr));
      @(negedge clk);
      check("R4 done drops", {31'd0, done}, 32'd0);
    end

    // R3 / R1 threshold extremes
    write_thr(1);
    wait_done("R1", cyc);
    check("R1 threshold 1 gives minimum", credit, ref_kth(cur_hz, 1));
    write_thr(16);
    wait_done("R1", cyc);
    check("R1 threshold 16 gives maximum", credit, ref_kth(cur_hz, 16));
    write_thr(0);
    wait_done("R3", cyc);
    check("R3 threshold 0 saturates", credit, ref_kth(cur_hz, 16));
    write_thr(1);
    wait_done("R1", cyc);
    write_thr(20);
    wait_done("R3", cyc);
    check("R3 threshold 20 saturates", credit, ref_kth(cur_hz, 16));

    // R8: identical horizons do nothing
    write_thr(7);
    wait_done("R8", cyc);
    held = credit;
    @(negedge clk);
    hz = cur_hz;
    count_dones(40, nd);
    check("R8 no result on same horizons", nd, 0);
    check("R8 credit held", credit, held);
    check("R8 stays idle", {31'd0, busy}, 32'd0);

    // R6: two updates inside one computation give one restart
    a_hz = build(101, 1'b0);
    b_hz = build(202, 1'b0);
    c_hz = build(303, 1'b1);
    @(negedge clk);
    hz = a_hz;
    repeat (4) @(negedge clk);
    hz = b_hz;
    repeat (3) @(negedge clk);
    hz = c_hz;
    wait_done("R6", cyc);
    check("R6 running result from first snapshot", credit, ref_kth(a_hz, 7));
    wait_done("R6", cyc);
    check("R6 restart uses latest horizons", credit, ref_kth(c_hz, 7));
    count_dones(60, nd);
    check("R6 exactly one restart", nd, 0);

    summary();
    $finish;
  end

endmodule